// File: doc/BRIEF.md
# Dual-Register Output Logic Cell

This block is one output cell of a small programmable logic fabric. The AND/OR array sits outside the block and delivers two sum-of-products terms. The cell holds two state registers, and each register takes its next state from its own sum term. Per-register configuration bits make a register behave as a plain data register or as a toggle register. The same bits choose whether the register advances on the cell's own product-term clock qualifier or on the shared dedicated clock-pin qualifier. Both qualifiers are single-cycle strobes sampled on the chip's system clock `clk`.

Each register has its own asynchronous clear term, which takes effect at once. One synchronous preset line is shared by every cell. A test preload path can write a chosen level into either register. Register 0, or sum term 0 when the combinational bypass is set, drives the pad value through a polarity inverter. A product-term enable controls the pad driver. Register 1 stays buried. Both registers return to the array on separate feedback lines.

Top module: `dualreg_macrocell`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, both registers become 0, whatever the other inputs are.
- R2: A register whose `cfg_toggle` bit is 0 loads its sum term on an edge where its selected clock qualifier is high.
- R3: A register whose `cfg_toggle` bit is 1 inverts its state on a qualified edge when its sum term is 1, and keeps its state when the sum term is 0.
- R4: Register i is qualified by `pin_clk_en` when `cfg_pin_clk[i]` is 1 and by `pt_clk_en[i]` when it is 0. Without its qualifier the register holds its state.
- R5: While `areset[i]` is high, register i reads 0 immediately, before any clock edge. This clear outranks every other input.
- R6: On a qualified edge with `sync_preset` high and no preload, the register loads 1 in place of its data or toggle value.
- R7: On a qualified edge with `preload_en` high, register `preload_sel` loads `preload_data` (select 0 picks register 0, select 1 picks register 1). The other register holds its state. The value is written as given, whatever `cfg_invert` is, and preload outranks the preset.
- R8: `pad_data` equals register 0, or `sum_term[0]` when `cfg_bypass` is 1, XOR `cfg_invert`.
- R9: `pad_en` is high exactly when `oe_term` is high. When it is low, the pad driver is in the high-impedance state.
- R10: `fb[i]` always shows the true state of register i, not inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up clear |
| pin_clk_en | input | 1 | Dedicated clock-pin qualifier strobe |
| pt_clk_en | input | 2 | Per-register product-term clock qualifier |
| sum_term | input | 2 | Per-register sum-of-products next-state input |
| areset | input | 2 | Per-register asynchronous clear term, active high |
| sync_preset | input | 1 | Shared synchronous preset |
| oe_term | input | 1 | Pad output-enable product term |
| cfg_toggle | input | 2 | 1 = toggle register, 0 = data register |
| cfg_pin_clk | input | 2 | 1 = clock-pin qualifier, 0 = product-term qualifier |
| cfg_invert | input | 1 | Pad polarity inversion |
| cfg_bypass | input | 1 | Drive pad from sum term 0 instead of register 0 |
| preload_en | input | 1 | Test preload mode |
| preload_sel | input | 1 | Preload target register |
| preload_data | input | 1 | Level written by preload |
| pad_data | output | 1 | Value presented to the pad driver |
| pad_en | output | 1 | Pad driver enable, low = high impedance |
| fb | output | 2 | Per-register feedback to the array |

## Verification
The assertions assume that the clear terms and strobes are driven away from the `clk` edge. A clear term rising exactly at an edge would make the sampled feedback ambiguous. They also assume that the configuration bits are held steady over the cycle in which they take effect. The stimulus changes every input only at the falling edge. It changes the configuration bits only at phase boundaries, and it steps through all sixteen toggle and clock-source combinations. Clear, preset and preload are drawn at low rates, so that normal data and toggle updates outnumber them.

// File: rtl/mcell_pkg.sv
// mcell_pkg: shared helpers for the dual-register output cell.
// Assumes single-bit register state.
package mcell_pkg;

    // Update reason carried by each register on a qualified edge
    typedef enum logic [1:0] {
        UPD_NORMAL  = 2'd0,
        UPD_PRESET  = 2'd1,
        UPD_PRELOAD = 2'd2,
        UPD_HOLD    = 2'd3
    } upd_kind_e;

    // Data or toggle next-state rule
    function automatic logic dt_next(input logic cur, input logic term, input logic toggle);
        return toggle ? (cur ^ term) : term;
    endfunction

endpackage

// File: rtl/mcell_reg.sv
// mcell_reg: one cell register. It picks its clock qualifier, applies the
// data/toggle rule, the shared preset and the test preload, and clears at
// once on its own clear term.
// Assumes every strobe is synchronous to clk and areset is free-running.
module mcell_reg
    import mcell_pkg::*;
#(
    parameter int unsigned IDX  = 0,
    parameter int unsigned SELW = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            areset,
    input  logic            pin_clk_en,
    input  logic            pt_clk_en,
    input  logic            use_pin_clk,
    input  logic            toggle,
    input  logic            term,
    input  logic            sync_preset,
    input  logic            preload_en,
    input  logic [SELW-1:0] preload_sel,
    input  logic            preload_data,
    output logic            q
);

    logic      tick;
    logic      hit;
    upd_kind_e kind;
    logic      nxt;

    // Choose the clock qualifier for this register
    assign tick = use_pin_clk ? pin_clk_en : pt_clk_en;
    assign hit  = (preload_sel == SELW'(IDX));

    // Classify the edge: preload over preset over data/toggle
    always_comb begin
        if (preload_en)       kind = hit ? UPD_PRELOAD : UPD_HOLD;
        else if (sync_preset) kind = UPD_PRESET;
        else                  kind = UPD_NORMAL;
    end

    // Value loaded for each kind of edge
    always_comb begin
        unique case (kind)
            UPD_PRELOAD: nxt = preload_data;
            UPD_PRESET:  nxt = 1'b1;
            UPD_HOLD:    nxt = q;
            default:     nxt = dt_next(q, term, toggle);
        endcase
    end

    // State: immediate clear, then power-up clear, then qualified update
    always_ff @(posedge clk or posedge areset) begin
        if (areset)      q <= 1'b0;
        else if (!rst_n) q <= 1'b0;
        else if (tick)   q <= nxt;
    end

endmodule

// File: rtl/mcell_pad.sv
// mcell_pad: pad value selection and polarity. Register 0 or sum term 0
// drives the pad, XOR the polarity bit. The enable passes straight through.
// Assumes purely combinational use.
module mcell_pad (
    input  logic q0,
    input  logic term0,
    input  logic bypass,
    input  logic invert,
    input  logic oe_term,
    output logic pad_data,
    output logic pad_en
);

    logic src;

    // Pick the pad source
    assign src = bypass ? term0 : q0;

    // Apply polarity and the enable
    always_comb begin
        pad_data = src ^ invert;
        pad_en   = oe_term;
    end

endmodule

// File: rtl/dualreg_macrocell.sv
// dualreg_macrocell: output logic cell with NREG state registers, each with
// its own data/toggle and clock-source choice, feeding back separately.
// Register 0 (or sum term 0) drives the pad.
// Assumes inputs change away from the clk edge.
module dualreg_macrocell #(
    parameter int unsigned NREG = 2,
    localparam int unsigned SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_clk_en,
    input  logic [NREG-1:0] pt_clk_en,
    input  logic [NREG-1:0] sum_term,
    input  logic [NREG-1:0] areset,
    input  logic            sync_preset,
    input  logic            oe_term,
    input  logic [NREG-1:0] cfg_toggle,
    input  logic [NREG-1:0] cfg_pin_clk,
    input  logic            cfg_invert,
    input  logic            cfg_bypass,
    input  logic            preload_en,
    input  logic [SELW-1:0] preload_sel,
    input  logic            preload_data,
    output logic            pad_data,
    output logic            pad_en,
    output logic [NREG-1:0] fb
);

    logic [NREG-1:0] q;

    // One register per slot
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        mcell_reg #(.IDX(g), .SELW(SELW)) u_reg (
            .clk          (clk),
            .rst_n        (rst_n),
            .areset       (areset[g]),
            .pin_clk_en   (pin_clk_en),
            .pt_clk_en    (pt_clk_en[g]),
            .use_pin_clk  (cfg_pin_clk[g]),
            .toggle       (cfg_toggle[g]),
            .term         (sum_term[g]),
            .sync_preset  (sync_preset),
            .preload_en   (preload_en),
            .preload_sel  (preload_sel),
            .preload_data (preload_data),
            .q            (q[g])
        );
    end

    // Pad drive from register 0
    mcell_pad u_pad (
        .q0       (q[0]),
        .term0    (sum_term[0]),
        .bypass   (cfg_bypass),
        .invert   (cfg_invert),
        .oe_term  (oe_term),
        .pad_data (pad_data),
        .pad_en   (pad_en)
    );

    // Raw state to the array
    assign fb = q;

endmodule

// File: rtl/dualreg_macrocell_chk.sv
// dualreg_macrocell_chk: temporal checks on the cell, bound to every instance.
module dualreg_macrocell_chk #(
    parameter int unsigned NREG = 2,
    parameter int unsigned SELW = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pin_clk_en,
    input logic [NREG-1:0] pt_clk_en,
    input logic [NREG-1:0] sum_term,
    input logic [NREG-1:0] areset,
    input logic            sync_preset,
    input logic            cfg_invert,
    input logic            cfg_bypass,
    input logic [NREG-1:0] cfg_pin_clk,
    input logic            preload_en,
    input logic [SELW-1:0] preload_sel,
    input logic            preload_data,
    input logic            pad_data,
    input logic [NREG-1:0] fb
);

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        logic tk;
        assign tk = cfg_pin_clk[g] ? pin_clk_en : pt_clk_en[g];

        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            areset[g] |-> (fb[g] == 1'b0));  // R5

        AST_HOLD_UNQUALIFIED: assert property (@(posedge clk) disable iff (!rst_n || areset[g])
            !tk |=> $stable(fb[g]));  // R4

        AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n || areset[g])
            (tk && sync_preset && !preload_en) |=> fb[g]);  // R6

        AST_PRELOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n || areset[g])
            (tk && preload_en && preload_sel == SELW'(g)) |=> (fb[g] == $past(preload_data)));  // R7
    end

    AST_PAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (pad_data == ((cfg_bypass ? sum_term[0] : fb[0]) ^ cfg_invert)));  // R8

endmodule

bind dualreg_macrocell dualreg_macrocell_chk #(.NREG(NREG), .SELW(SELW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_clk_en   (pin_clk_en),
    .pt_clk_en    (pt_clk_en),
    .sum_term     (sum_term),
    .areset       (areset),
    .sync_preset  (sync_preset),
    .cfg_invert   (cfg_invert),
    .cfg_bypass   (cfg_bypass),
    .cfg_pin_clk  (cfg_pin_clk),
    .preload_en   (preload_en),
    .preload_sel  (preload_sel),
    .preload_data (preload_data),
    .pad_data     (pad_data),
    .fb           (fb)
);

// File: tb/dualreg_macrocell_test.sv
// dualreg_macrocell_test: random plus directed stimulus against a bench model.
module dualreg_macrocell_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pin_clk_en;
    logic [1:0] pt_clk_en;
    logic [1:0] sum_term;
    logic [1:0] areset;
    logic       sync_preset;
    logic       oe_term;
    logic [1:0] cfg_toggle;
    logic [1:0] cfg_pin_clk;
    logic       cfg_invert;
    logic       cfg_bypass;
    logic       preload_en;
    logic       preload_sel;
    logic       preload_data;
    logic       pad_data;
    logic       pad_en;
    logic [1:0] fb;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic  mq [2];
    string why [2];

    always #2 clk = ~clk;   // 250 MHz

    dualreg_macrocell uut (
        .clk(clk), .rst_n(rst_n), .pin_clk_en(pin_clk_en), .pt_clk_en(pt_clk_en),
        .sum_term(sum_term), .areset(areset), .sync_preset(sync_preset), .oe_term(oe_term),
        .cfg_toggle(cfg_toggle), .cfg_pin_clk(cfg_pin_clk), .cfg_invert(cfg_invert),
        .cfg_bypass(cfg_bypass), .preload_en(preload_en), .preload_sel(preload_sel),
        .preload_data(preload_data), .pad_data(pad_data), .pad_en(pad_en), .fb(fb)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Model update for one register at a rising edge
    function automatic logic model_step(input int i, input logic cur, output string r);
        logic tk;
        tk = cfg_pin_clk[i] ? pin_clk_en : pt_clk_en[i];
        if (areset[i])   begin r = "R5"; return 1'b0; end
        if (!rst_n)      begin r = "R1"; return 1'b0; end
        if (!tk)         begin r = "R4"; return cur; end
        if (preload_en) begin
            r = "R7";
            return (int'(preload_sel) == i) ? preload_data : cur;
        end
        if (sync_preset) begin r = "R6"; return 1'b1; end
        if (cfg_toggle[i]) begin r = "R3"; return cur ^ sum_term[i]; end
        r = "R2";
        return sum_term[i];
    endfunction

    function automatic logic exp_pad();
        return (cfg_bypass ? sum_term[0] : mq[0]) ^ cfg_invert;
    endfunction

    task automatic check_all();
        check({why[0], "/R10 fb0"}, fb[0], mq[0]);
        check({why[1], "/R10 fb1"}, fb[1], mq[1]);
        check("R8 pad_data", pad_data, exp_pad());
        check("R9 pad_en", pad_en, oe_term);
    endtask

    // One cycle: drive at the falling edge, check the clear at once, then step the model
    task automatic cycle();
        for (int i = 0; i < 2; i++) if (areset[i]) mq[i] = 1'b0;
        #0.5;
        for (int i = 0; i < 2; i++)
            if (areset[i]) check("R5 immediate clear", fb[i], 1'b0);
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            string r;
            mq[i] = model_step(i, mq[i], r);
            why[i] = r;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic rand_inputs();
        pin_clk_en   = ($urandom % 4) != 0;
        pt_clk_en    = 2'($urandom);
        sum_term     = 2'($urandom);
        areset[0]    = ($urandom % 16) == 0;
        areset[1]    = ($urandom % 16) == 0;
        sync_preset  = ($urandom % 8) == 0;
        preload_en   = ($urandom % 8) == 0;
        preload_sel  = 1'($urandom);
        preload_data = 1'($urandom);
        oe_term      = 1'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        mq[0] = 1'b0; mq[1] = 1'b0; why[0] = "R1"; why[1] = "R1";
        rst_n = 1'b0; pin_clk_en = 1'b1; pt_clk_en = 2'b11; sum_term = 2'b11;
        areset = 2'b00; sync_preset = 1'b0; oe_term = 1'b0; cfg_toggle = 2'b00;
        cfg_pin_clk = 2'b00; cfg_invert = 1'b0; cfg_bypass = 1'b0;
        preload_en = 1'b0; preload_sel = 1'b0; preload_data = 1'b0;
        // R1: reset state with all data lines high
        repeat (3) @(negedge clk);
        check("R1 reset fb0", fb[0], 1'b0);
        check("R1 reset fb1", fb[1], 1'b0);
        check("R9 pad_en off", pad_en, 1'b0);
        rst_n = 1'b1;

        // Directed R7: preload ignores the pad polarity, then selects register 1
        cfg_invert = 1'b1; oe_term = 1'b1; sum_term = 2'b00;
        preload_en = 1'b1; preload_sel = 1'b0; preload_data = 1'b1; pt_clk_en = 2'b11;
        cycle();
        check("R7 preload raw reg0", fb[0], 1'b1);
        check("R7 reg1 untouched", fb[1], 1'b0);
        preload_sel = 1'b1; preload_data = 1'b1; sync_preset = 1'b1;
        cycle();
        check("R7 preload reg1 over preset", fb[1], 1'b1);
        check("R7 reg0 holds", fb[0], 1'b1);
        preload_en = 1'b0; sync_preset = 1'b0;

        // Directed R3: toggle with sum 1 flips both registers
        cfg_toggle = 2'b11; sum_term = 2'b11;
        cycle();
        check("R3 toggle reg0", fb[0], 1'b0);
        check("R3 toggle reg1", fb[1], 1'b0);

        // Random phases over every toggle/clock-source combination
        for (int ph = 0; ph < 32; ph++) begin
            cfg_toggle  = 2'(ph);
            cfg_pin_clk = 2'(ph >> 2);
            cfg_invert  = 1'($urandom);
            cfg_bypass  = 1'($urandom);
            for (int k = 0; k < 120; k++) begin
                rand_inputs();
                if (k == 60 && ph % 8 == 3) rst_n = 1'b0;
                cycle();
                rst_n = 1'b1;
            end
        end

        // Directed R5 over a held preset: the clear wins
        areset = 2'b11; sync_preset = 1'b1; pin_clk_en = 1'b1; pt_clk_en = 2'b11;
        preload_en = 1'b0;
        cycle();
        check("R5 clear over preset fb0", fb[0], 1'b0);
        check("R5 clear over preset fb1", fb[1], 1'b0);
        areset = 2'b00;
        cycle();
        check("R6 preset after clear", fb[0], 1'b1);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule